// File: doc/BRIEF.md
# Manchester IR packet transmitter

This block sends a short packet of bytes as an infrared frame. A one-cycle start request captures a parallel word of data bytes and a half-symbol length. The block then drives an LED pin with a Manchester-coded frame: a run of one-symbols ended by a zero-symbol as a preamble, then every data byte, then a CRC-8 check byte over the data. Each byte is followed by two framing symbols. Whenever a half-symbol is "lit", the pin carries a roughly 50% duty carrier near 38 kHz. Whenever a half-symbol is "dark", the pin stays low.

The carrier divisor and the default half-symbol length of 350 microseconds are both derived from the clock frequency parameter, rounded to the nearest integer. The number of data bytes is a parameter. The CRC is computed one bit per clock from the captured bytes while the preamble is being sent. A busy flag covers the whole frame, and a one-cycle done pulse marks its end.

Top module: `irtx_manchester_tx`

## Requirements
- R1: While reset is applied, and after reset until the first accepted start, `led`, `busy` and `done` are all 0.
- R2: A frame opens with 20 one-symbols followed by one zero-symbol, which makes 42 half-symbols.
- R3: Next come the data bytes. Byte 0 is `data_in[7:0]` and goes first, byte i is `data_in[8i+7:8i]`. Each byte is sent as 8 symbols, most significant bit first, followed by a one-symbol and then a zero-symbol.
- R4: A zero-symbol is a lit half followed by a dark half. A one-symbol is a dark half followed by a lit half.
- R5: Carrier timing is set by DIV = round(CLK_HZ/CARRIER_HZ). In a lit half, `led` is high for the first DIV/2 (rounded down) cycles of every DIV-cycle carrier period, and the carrier phase restarts at 0 on the first cycle of every half. In a dark half, and whenever the block is idle, `led` is 0.
- R6: After the last data byte, the block sends a check byte with the same 10-symbol framing. The check byte is a CRC-8 with polynomial 0x31 and seed 0xFF, processed MSB first over the data bytes in sending order only.
- R7: Every half-symbol lasts exactly `half_len` cycles, using the value captured when start is accepted. A captured value of 0 selects the default round(CLK_HZ × 350 µs).
- R8: A start is accepted only while `busy` is 0. A start while busy is ignored. Changes to `data_in` or `half_len` after acceptance do not affect the frame in progress.
- R9: `busy` rises in the cycle after the accepting edge and stays high through the final half. In the cycle after the final half, `busy` is 0 and `done` is 1 for exactly one cycle.
- R10: A frame lasts exactly 2·(21 + 10·(NUM_BYTES+1)) half-symbols. With the default of 2 data bytes, that is 102 half-symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to send a frame; accepted only while idle |
| data_in | input | NUM_BYTES*8 | Data bytes; byte 0 in the lowest 8 bits |
| half_len | input | HLW | Half-symbol length in clock cycles; 0 selects the 350 µs default |
| led | output | 1 | Modulated LED drive |
| busy | output | 1 | High while a frame is being sent |
| done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
Count the accepting clock edge as cycle 0. Half-symbol k then occupies cycles k·H to k·H+H−1, so every `led` result is due at a fixed cycle. The bench samples each of those cycles on the falling edge and compares the first cycle of each half with the expected carrier phase. It also compares the count of high cycles in each half with the number the carrier period predicts. `done` is due exactly 102·H cycles after acceptance, with `busy` already low in that same cycle. The bench checks that cycle and the one after it, so an early or late end, or a pulse longer than one cycle, is reported.

// File: rtl/irtx_pkg.sv
package irtx_pkg;

    // Frame shape
    localparam int HEADER_ONES = 20;
    localparam int HEADER_SYMS = HEADER_ONES + 1;
    localparam int BYTE_BITS   = 8;
    localparam int BYTE_SYMS   = BYTE_BITS + 2;

    // Check byte
    localparam logic [7:0] CRC_POLY = 8'h31;
    localparam logic [7:0] CRC_SEED = 8'hFF;

    // Default half-symbol time in microseconds
    localparam int HALF_US_DEFAULT = 350;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_HEADER = 2'd1,
        SEQ_BYTES  = 2'd2
    } seq_state_e;

    // Request from sequencer to carrier: restart phase, and lit/dark level
    typedef struct packed {
        logic load;
        logic on;
    } half_req_t;

    function automatic int div_round(longint num, longint den);
        return int'((num + den / 2) / den);
    endfunction

    // One MSB-first CRC step on a single input bit
    function automatic logic [7:0] crc8_step(logic [7:0] crc, logic din);
        logic fb;
        fb = crc[7] ^ din;
        return {crc[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
    endfunction

endpackage

// File: rtl/irtx_half_timer.sv
module irtx_half_timer
    import irtx_pkg::*;
#(
    parameter int HLW          = 16,
    parameter int HALF_DEFAULT = 17500
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [HLW-1:0] half_len,
    input  logic           run,
    output logic           half_end
);

    localparam logic [HLW-1:0] DEF_LEN = HLW'(HALF_DEFAULT);

    logic [HLW-1:0] hlen_q;
    logic [HLW-1:0] hcnt;

    assign half_end = run && (hcnt == hlen_q - HLW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            hlen_q <= DEF_LEN;
            hcnt   <= '0;
        end else if (load) begin
            hlen_q <= (half_len == '0) ? DEF_LEN : half_len;
            hcnt   <= '0;
        end else if (run) begin
            hcnt <= half_end ? '0 : hcnt + HLW'(1);
        end
    end

    AST_HALF_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        run |-> (hcnt < hlen_q)); // R7
    AST_HALF_NONZERO: assert property (@(posedge clk) disable iff (rst)
        hlen_q != '0); // R7

endmodule

// File: rtl/irtx_carrier.sv
module irtx_carrier
    import irtx_pkg::*;
#(
    parameter int DIV  = 1316,
    parameter int HIGH = DIV / 2
) (
    input  logic      clk,
    input  logic      rst,
    input  half_req_t req,
    output logic      led
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] ccnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ccnt <= '0;
        end else if (req.load || ccnt == CW'(DIV - 1)) begin
            ccnt <= '0;
        end else begin
            ccnt <= ccnt + CW'(1);
        end
    end

    assign led = req.on && (ccnt < CW'(HIGH));

    AST_CARRIER_PHASE: assert property (@(posedge clk) disable iff (rst)
        req.load |=> (led == req.on)); // R5
    AST_CARRIER_WRAP: assert property (@(posedge clk) disable iff (rst)
        ccnt < CW'(DIV - 1) || ccnt == CW'(DIV - 1)); // R5

endmodule

// File: rtl/irtx_crc8.sv
module irtx_crc8
    import irtx_pkg::*;
#(
    parameter int NUM_BYTES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   go,
    input  logic [NUM_BYTES*8-1:0] buf_q,
    output logic [7:0]             crc,
    output logic                   ready
);

    localparam int NBITS = NUM_BYTES * BYTE_BITS;
    localparam int CNTW  = $clog2(NBITS);

    logic [CNTW-1:0] cnt;
    logic            running;
    logic            cur_bit;

    // Bit k of the stream is byte k/8, bit 7-(k%8): flip the low three index bits
    assign cur_bit = buf_q[cnt ^ CNTW'(7)];

    always_ff @(posedge clk) begin
        if (rst) begin
            crc     <= CRC_SEED;
            cnt     <= '0;
            running <= 1'b0;
            ready   <= 1'b0;
        end else if (go) begin
            crc     <= CRC_SEED;
            cnt     <= '0;
            running <= 1'b1;
            ready   <= 1'b0;
        end else if (running) begin
            crc <= crc8_step(crc, cur_bit);
            cnt <= cnt + CNTW'(1);
            if (cnt == CNTW'(NBITS - 1)) begin
                running <= 1'b0;
                ready   <= 1'b1;
            end
        end
    end

    AST_CRC_NOT_BOTH: assert property (@(posedge clk) disable iff (rst)
        !(running && ready)); // R6

endmodule

// File: rtl/irtx_sequencer.sv
module irtx_sequencer
    import irtx_pkg::*;
#(
    parameter int NUM_BYTES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_acc,
    input  logic [NUM_BYTES*8-1:0] data_in,
    input  logic [7:0]             crc_val,
    input  logic                   crc_ready,
    input  logic                   half_end,
    output logic [NUM_BYTES*8-1:0] buf_q,
    output logic                   busy,
    output logic                   done,
    output half_req_t              req
);

    localparam int BIW = $clog2(NUM_BYTES + 1);

    seq_state_e     state;
    logic [BIW-1:0] byte_idx;
    logic [4:0]     sym_idx;
    logic           phase;
    logic [7:0]     sel_byte;
    logic           sym_bit;
    logic           is_check;

    assign busy     = (state != SEQ_IDLE);
    assign is_check = (byte_idx == BIW'(NUM_BYTES));

    always_comb begin
        sel_byte = crc_val;
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (byte_idx == BIW'(i)) sel_byte = buf_q[i*8 +: 8];
        end
        case (state)
            SEQ_HEADER: sym_bit = (sym_idx < 5'(HEADER_ONES));
            SEQ_BYTES:  sym_bit = (sym_idx < 5'(BYTE_BITS)) ? sel_byte[~sym_idx[2:0]]
                                                            : (sym_idx == 5'(BYTE_BITS));
            default:    sym_bit = 1'b0;
        endcase
        req.on   = busy && (phase ? sym_bit : !sym_bit);
        req.load = start_acc || half_end;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEQ_IDLE;
            buf_q    <= '0;
            byte_idx <= '0;
            sym_idx  <= '0;
            phase    <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start_acc) begin
                state    <= SEQ_HEADER;
                buf_q    <= data_in;
                byte_idx <= '0;
                sym_idx  <= '0;
                phase    <= 1'b0;
            end else if (half_end) begin
                if (!phase) begin
                    phase <= 1'b1;
                end else begin
                    phase <= 1'b0;
                    if (state == SEQ_HEADER) begin
                        if (sym_idx == 5'(HEADER_SYMS - 1)) begin
                            state    <= SEQ_BYTES;
                            sym_idx  <= '0;
                            byte_idx <= '0;
                        end else begin
                            sym_idx <= sym_idx + 5'd1;
                        end
                    end else if (sym_idx == 5'(BYTE_SYMS - 1)) begin
                        sym_idx <= '0;
                        if (is_check) begin
                            state <= SEQ_IDLE;
                            done  <= 1'b1;
                        end else begin
                            byte_idx <= byte_idx + BIW'(1);
                        end
                    end else begin
                        sym_idx <= sym_idx + 5'd1;
                    end
                end
            end
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> (state == SEQ_IDLE)); // R9
    AST_CRC_READY: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_BYTES && is_check) |-> crc_ready); // R6
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (busy && !half_end) |=> busy); // R8
    AST_HEADER_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_HEADER) |-> (sym_idx < 5'(HEADER_SYMS))); // R2
    AST_BYTE_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_BYTES) |-> (sym_idx < 5'(BYTE_SYMS) && byte_idx <= BIW'(NUM_BYTES))); // R3

endmodule

// File: rtl/irtx_manchester_tx.sv
module irtx_manchester_tx
    import irtx_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int CARRIER_HZ = 38_000,
    parameter int NUM_BYTES  = 2,
    parameter int HLW        = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [NUM_BYTES*8-1:0] data_in,
    input  logic [HLW-1:0]         half_len,
    output logic                   led,
    output logic                   busy,
    output logic                   done
);

    localparam int CARR_DIV     = div_round(longint'(CLK_HZ), longint'(CARRIER_HZ));
    localparam int CARR_HIGH    = CARR_DIV / 2;
    localparam int HALF_DEFAULT = div_round(longint'(CLK_HZ) * HALF_US_DEFAULT, 64'd1_000_000);

    logic                   start_acc;
    logic                   half_end;
    logic [NUM_BYTES*8-1:0] buf_q;
    logic [7:0]             crc_val;
    logic                   crc_ready;
    half_req_t              req;

    assign start_acc = start && !busy;

    irtx_half_timer #(.HLW(HLW), .HALF_DEFAULT(HALF_DEFAULT)) u_timer (
        .clk(clk), .rst(rst), .load(start_acc), .half_len(half_len),
        .run(busy), .half_end(half_end)
    );

    irtx_sequencer #(.NUM_BYTES(NUM_BYTES)) u_seq (
        .clk(clk), .rst(rst), .start_acc(start_acc), .data_in(data_in),
        .crc_val(crc_val), .crc_ready(crc_ready), .half_end(half_end),
        .buf_q(buf_q), .busy(busy), .done(done), .req(req)
    );

    irtx_crc8 #(.NUM_BYTES(NUM_BYTES)) u_crc (
        .clk(clk), .rst(rst), .go(start_acc), .buf_q(buf_q),
        .crc(crc_val), .ready(crc_ready)
    );

    irtx_carrier #(.DIV(CARR_DIV), .HIGH(CARR_HIGH)) u_carrier (
        .clk(clk), .rst(rst), .req(req), .led(led)
    );

    AST_IDLE_DARK: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !led); // R5
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R9
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy || done)); // R8

endmodule

// File: tb/irtx_manchester_tx_bench.sv
module irtx_manchester_tx_bench;

    localparam int NB   = 2;
    localparam int DIV  = 10;   // 380 kHz / 38 kHz
    localparam int HIGH = 5;
    localparam int HDEF = 133;  // round(380000 * 350e-6)
    localparam int NH   = (21 + 10 * (NB + 1)) * 2;
    localparam int HDR_H = 42;
    localparam int DAT_H = HDR_H + 20 * NB;

    // stimulus vectors: {data, half_len}
    localparam logic [31:0] VEC [5] = '{
        {16'hA55A, 16'd20}, {16'h0000, 16'd13}, {16'hFFFF, 16'd7},
        {16'h1234, 16'd1},  {16'hC380, 16'd25}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [15:0]   data_in;
    logic [15:0]   half_len;
    logic          led, busy, done;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    bit exp_on [0:NH-1];

    always #10 clk = ~clk;
    always @(posedge clk) cyc++;

    irtx_manchester_tx #(.CLK_HZ(380_000), .CARRIER_HZ(38_000), .NUM_BYTES(NB), .HLW(16))
    u_irtx_manchester_tx (
        .clk(clk), .rst(rst), .start(start), .data_in(data_in), .half_len(half_len),
        .led(led), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_crc(input logic [15:0] d);
        logic [7:0] c = 8'hFF;
        for (int i = 0; i < NB; i++) begin
            for (int j = 7; j >= 0; j--) begin
                logic fb = c[7] ^ d[i*8 + j];
                c = {c[6:0], 1'b0} ^ (fb ? 8'h31 : 8'h00);
            end
        end
        return c;
    endfunction

    task automatic build_expected(input logic [15:0] d);
        int k = 0;
        logic [7:0] b;
        // header R2, symbol halves R4
        for (int s = 0; s < 21; s++) begin
            exp_on[k] = !(s < 20); exp_on[k+1] = (s < 20); k += 2;
        end
        for (int by = 0; by <= NB; by++) begin
            b = (by == NB) ? ref_crc(d) : d[by*8 +: 8];
            for (int s = 0; s < 10; s++) begin
                bit v = (s < 8) ? b[7 - s] : (s == 8);
                exp_on[k] = !v; exp_on[k+1] = v; k += 2;
            end
        end
    endtask

    task automatic run_frame(input logic [15:0] d, input int hl, input int poke);
        int h = (hl == 0) ? HDEF : hl;
        int exp_hi = (h / DIV) * HIGH + ((h % DIV) < HIGH ? (h % DIV) : HIGH);
        int hdr_err = 0, dat_err = 0, crc_err = 0, busy_err = 0;
        build_expected(d);
        @(negedge clk);
        data_in = d; half_len = 16'(hl); start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0; data_in = ~d; half_len = 16'(hl + 3);
        for (int k = 0; k < NH; k++) begin
            int hi = 0;
            bit first = 1'b0;
            bit ok;
            for (int c = 0; c < h; c++) begin
                start = (k * h + c == poke);
                if (c == 0) first = led;
                if (led) hi++;
                if (!busy || done) busy_err++;
                @(negedge clk);
            end
            ok = exp_on[k] ? (first && hi == exp_hi) : (hi == 0);
            if (!ok) begin
                if (k < HDR_H) hdr_err++;
                else if (k < DAT_H) dat_err++;
                else crc_err++;
            end
        end
        start = 1'b0;
        check(hdr_err == 0, "R2 R4 R5 header halves wrong", hdr_err, 0);
        check(dat_err == 0, "R3 R4 R5 R8 data halves wrong", dat_err, 0);
        check(crc_err == 0, "R6 check byte halves wrong", crc_err, 0);
        check(busy_err == 0, "R7 R9 busy/done during frame", busy_err, 0);
        check(done === 1'b1 && busy === 1'b0, "R9 R10 end of frame done/busy",
              {30'd0, done, busy}, 2);
        @(negedge clk);
        check(done === 1'b0, "R9 done single cycle", done, 0);
    endtask

    initial begin
        wait (cyc >= 150000);
        fails++;
        $display("FAIL R9 watchdog expired actual=%0d expected=<150000", cyc);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; data_in = '0; half_len = '0;
        repeat (3) @(negedge clk);
        check(led === 1'b0 && busy === 1'b0 && done === 1'b0, "R1 in reset",
              {29'd0, led, busy, done}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(led === 1'b0 && busy === 1'b0 && done === 1'b0, "R1 idle after reset",
              {29'd0, led, busy, done}, 0);

        foreach (VEC[i]) run_frame(VEC[i][31:16], int'(VEC[i][15:0]), -1);

        // R7: zero length selects the default half time
        run_frame(16'h5AC3, 0, -1);
        // R8: start pulsed mid-frame with different inputs is ignored
        run_frame(16'h0F1E, 16, 300);
        run_frame(16'h0F1E, 16, 16 * NH - 1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule